// File: doc/BRIEF.md
# Windowed Modular Exponentiation Sequencer

The block raises a base to an exponent modulo a chosen modulus with the fixed-window method. When a run starts, it first fills a small local table with successive powers of the base (entry 0 holds one, and each later entry is the one before it times the base). It then walks the exponent from its most significant end, `M` bits at a time. For every window it squares the accumulator `M` times and then multiplies once by the table entry that the window value selects.

Every multiplication, squarings included, goes through one general serial modular multiplier, which sits inside the block so the block can be checked on its own. The multiplier start pulse, the kind of operation and the table address are brought out as ports. The operation trace at the ports depends only on the parameters and never on the exponent. A window of zeros still costs a multiplication, by entry 0. A blinded exponent, which is the key plus a random multiple of the totient, only needs a wider `EW`: any extra leading windows are processed like the others.

Top module: `wexp_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o`, `done_o` and `mul_go_o` are 0.
- R2: `start_i` sampled high while idle latches the base, modulus and exponent and raises `busy_o` in the next cycle. `start_i` sampled while busy is ignored: the running result is unchanged by it.
- R3: Before any squaring, exactly 2^M−1 table-fill multiplications run. Each has `mul_kind_o`=1, and `tbl_addr_o` takes the values 1, 2, …, 2^M−1 in increasing order.
- R4: For base < modulus and modulus ≥ 2, `result_o` while `done_o` is high equals base^exp mod modulus. An exponent of 0 gives 1.
- R5: Windows are processed from the most significant downward, with ND = ceil(EW/M). Each window issues exactly M squarings (`mul_kind_o`=2) and then one table multiplication (`mul_kind_o`=3) with `tbl_addr_o` equal to the window value.
- R6: A zero window still issues its table multiplication, at address 0. Every run issues (2^M−1)+ND·(M+1) multiplier starts, and the number of cycles from start to done is the same for every operand set.
- R7: `done_o` is a single-cycle pulse. `busy_o` is low in that cycle.
- R8: `mul_go_o` is asserted only while busy, always with a nonzero `mul_kind_o`, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| base_i | input | W | Base, below the modulus |
| mod_i | input | W | Modulus, at least 2 |
| exp_i | input | EW | Exponent, possibly blinded |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| result_o | output | W | Accumulator contents |
| mul_go_o | output | 1 | Multiplier start pulse |
| mul_kind_o | output | 2 | 0 none, 1 table fill, 2 square, 3 table multiply |
| tbl_addr_o | output | M | Table entry written (fill) or read (table multiply) |

## Verification
On every cycle, the checker confirms the operation grammar: fills come first and in order, each table multiplication is preceded by exactly M squarings, done is a lone pulse while idle, and multiplier starts are spaced and only occur while busy. Only the bench scenarios can show that the arithmetic is right against an independent square-and-multiply reference. The same scenarios show that each table address equals the exponent window it should. They also show that the operation count and the latency do not change with the exponent, including zero and single-nonzero-window exponents, and that a start request during a run changes nothing.

// File: rtl/wexp_pkg.sv
// Shared types for the windowed exponentiation sequencer.
// Assumes nothing beyond a two-bit operation code seen at the top ports.
package wexp_pkg;
    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_FILL = 2'd1,
        OPK_SQR  = 2'd2,
        OPK_TBL  = 2'd3
    } opk_e;
endpackage

// File: rtl/wexp_modmul.sv
// Bit-serial modular multiplier: p = a*b mod n, one bit of b per cycle, MSB first.
// Assumes a < n and n >= 2; both are held internally from the go pulse.
// The done pulse arrives W cycles after go, whatever the operand values.
module wexp_modmul #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] n,
    output logic         done,
    output logic [W-1:0] p
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  a_q, b_q, n_q, r_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    dbl, sum;
    logic [W-1:0]  red1, red2;

    // One interleaved step: double, reduce, conditionally add, reduce.
    always_comb begin
        dbl  = {r_q, 1'b0};
        red1 = W'((dbl >= {1'b0, n_q}) ? dbl - {1'b0, n_q} : dbl);
        sum  = {1'b0, red1} + (b_q[W-1] ? {1'b0, a_q} : '0);
        red2 = W'((sum >= {1'b0, n_q}) ? sum - {1'b0, n_q} : sum);
    end

    // Operand capture, step iteration and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0; b_q <= '0; n_q <= '0; r_q <= '0;
            cnt_q <= '0; run_q <= 1'b0; done <= 1'b0;
        end else if (go) begin
            a_q <= a; b_q <= b; n_q <= n; r_q <= '0;
            cnt_q <= CW'(W); run_q <= 1'b1; done <= 1'b0;
        end else if (run_q) begin
            r_q   <= red2;
            b_q   <= {b_q[W-2:0], 1'b0};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
                run_q <= 1'b0;
                done  <= 1'b1;
            end else begin
                done <= 1'b0;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign p = r_q;
endmodule

// File: rtl/wexp_table.sv
// Power table: 2^M entries of W bits, one synchronous write port and one
// asynchronous read port. Assumes every entry is written before it is read.
module wexp_table #(
    parameter int W = 32,
    parameter int M = 4
) (
    input  logic         clk,
    input  logic         we,
    input  logic [M-1:0] waddr,
    input  logic [W-1:0] wdata,
    input  logic [M-1:0] raddr,
    output logic [W-1:0] rdata
);
    localparam int DEPTH = 1 << M;

    logic [W-1:0] mem [DEPTH];

    // Store a freshly computed power.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/wexp_ctrl.sv
// Sequencer: fills the power table, then runs M squarings plus one table
// multiply per exponent window, most significant window first, with no
// branch on window values. Assumes the multiplier answers each go with done.
module wexp_ctrl
    import wexp_pkg::*;
#(
    parameter int W  = 32,
    parameter int M  = 4,
    parameter int EW = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] base,
    input  logic [W-1:0] modv,
    input  logic [EW-1:0] expv,
    output logic         mul_go,
    output opk_e         mul_kind,
    output logic [W-1:0] op_a,
    output logic [W-1:0] op_b,
    output logic [W-1:0] op_n,
    input  logic         mul_done,
    input  logic [W-1:0] mul_p,
    output logic         tbl_we,
    output logic [M-1:0] tbl_waddr,
    output logic [W-1:0] tbl_wdata,
    output logic [M-1:0] tbl_raddr,
    input  logic [W-1:0] tbl_rdata,
    output logic [M-1:0] tbl_addr,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] acc
);
    localparam int ND = (EW + M - 1) / M;
    localparam int PW = ND * M;
    localparam int DW = (ND > 1) ? $clog2(ND) : 1;
    localparam int SW = $clog2(M + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_FILL_GO, S_FILL_WAIT, S_SQ_GO, S_SQ_WAIT, S_TM_GO, S_TM_WAIT
    } st_e;

    st_e           st_q;
    logic [W-1:0]  g_q, n_q, prev_q, acc_q;
    logic [PW-1:0] e_q;
    logic [M-1:0]  fidx_q;
    logic [DW-1:0] dig_q;
    logic [SW-1:0] sqc_q;
    logic          done_q;
    logic [M-1:0]  win;

    // Current exponent window, selected by the digit index.
    assign win = e_q[dig_q*M +: M];

    // Operation issue: operands, kind and table address per state.
    always_comb begin
        mul_go   = 1'b0;
        mul_kind = OPK_NONE;
        op_a     = acc_q;
        op_b     = acc_q;
        tbl_addr = '0;
        case (st_q)
            S_FILL_GO: begin
                mul_go = 1'b1; mul_kind = OPK_FILL;
                op_a = prev_q; op_b = g_q; tbl_addr = fidx_q;
            end
            S_SQ_GO: begin
                mul_go = 1'b1; mul_kind = OPK_SQR;
            end
            S_TM_GO: begin
                mul_go = 1'b1; mul_kind = OPK_TBL;
                op_b = tbl_rdata; tbl_addr = win;
            end
            default: ;
        endcase
    end

    // Table write: entry 0 on start, later entries as fill products arrive.
    always_comb begin
        tbl_we    = 1'b0;
        tbl_waddr = fidx_q;
        tbl_wdata = mul_p;
        if (st_q == S_IDLE && start) begin
            tbl_we = 1'b1; tbl_waddr = '0; tbl_wdata = W'(1);
        end else if (st_q == S_FILL_WAIT && mul_done) begin
            tbl_we = 1'b1;
        end
    end

    // Main state machine and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
            g_q <= '0; n_q <= '0; prev_q <= '0; acc_q <= '0; e_q <= '0;
            fidx_q <= '0; dig_q <= '0; sqc_q <= '0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                S_IDLE: if (start) begin
                    g_q    <= base;
                    n_q    <= modv;
                    e_q    <= PW'(expv);
                    prev_q <= W'(1);
                    fidx_q <= M'(1);
                    st_q   <= S_FILL_GO;
                end
                S_FILL_GO: st_q <= S_FILL_WAIT;
                S_FILL_WAIT: if (mul_done) begin
                    prev_q <= mul_p;
                    if (fidx_q == '1) begin
                        acc_q <= W'(1);
                        dig_q <= DW'(ND - 1);
                        sqc_q <= '0;
                        st_q  <= S_SQ_GO;
                    end else begin
                        fidx_q <= fidx_q + 1'b1;
                        st_q   <= S_FILL_GO;
                    end
                end
                S_SQ_GO: st_q <= S_SQ_WAIT;
                S_SQ_WAIT: if (mul_done) begin
                    acc_q <= mul_p;
                    if (sqc_q == SW'(M - 1)) begin
                        sqc_q <= '0;
                        st_q  <= S_TM_GO;
                    end else begin
                        sqc_q <= sqc_q + 1'b1;
                        st_q  <= S_SQ_GO;
                    end
                end
                S_TM_GO: st_q <= S_TM_WAIT;
                S_TM_WAIT: if (mul_done) begin
                    acc_q <= mul_p;
                    if (dig_q == '0) begin
                        done_q <= 1'b1;
                        st_q   <= S_IDLE;
                    end else begin
                        dig_q <= dig_q - 1'b1;
                        st_q  <= S_SQ_GO;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign tbl_raddr = win;
    assign op_n      = n_q;
    assign busy      = (st_q != S_IDLE);
    assign done      = done_q;
    assign acc       = acc_q;
endmodule

// File: rtl/wexp_seq.sv
// Top of the windowed exponentiation sequencer: controller, power table and
// the shared serial modular multiplier. Assumes base < modulus, modulus >= 2.
module wexp_seq
    import wexp_pkg::*;
#(
    parameter int W  = 32,
    parameter int M  = 4,
    parameter int EW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [W-1:0]  base_i,
    input  logic [W-1:0]  mod_i,
    input  logic [EW-1:0] exp_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [W-1:0]  result_o,
    output logic          mul_go_o,
    output logic [1:0]    mul_kind_o,
    output logic [M-1:0]  tbl_addr_o
);
    logic         mul_go, mul_done, tbl_we;
    opk_e         mul_kind;
    logic [W-1:0] op_a, op_b, op_n, mul_p, tbl_wdata, tbl_rdata;
    logic [M-1:0] tbl_waddr, tbl_raddr;

    wexp_ctrl #(.W(W), .M(M), .EW(EW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start_i),
        .base(base_i), .modv(mod_i), .expv(exp_i),
        .mul_go(mul_go), .mul_kind(mul_kind),
        .op_a(op_a), .op_b(op_b), .op_n(op_n),
        .mul_done(mul_done), .mul_p(mul_p),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .tbl_raddr(tbl_raddr), .tbl_rdata(tbl_rdata),
        .tbl_addr(tbl_addr_o), .busy(busy_o), .done(done_o), .acc(result_o)
    );

    wexp_table #(.W(W), .M(M)) u_tbl (
        .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
        .raddr(tbl_raddr), .rdata(tbl_rdata)
    );

    wexp_modmul #(.W(W)) u_mul (
        .clk(clk), .rst_n(rst_n), .go(mul_go),
        .a(op_a), .b(op_b), .n(op_n), .done(mul_done), .p(mul_p)
    );

    assign mul_go_o   = mul_go;
    assign mul_kind_o = mul_kind;
endmodule

// File: rtl/wexp_chk.sv
// Checker for the operation grammar seen at the sequencer's ports.
// Assumes the kind encoding 1 fill, 2 square, 3 table multiply.
module wexp_chk #(
    parameter int M = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         mul_go,
    input logic [1:0]   mul_kind,
    input logic [M-1:0] tbl_addr
);
    localparam int SRW = $clog2(M + 1) + 1;

    logic [M:0]     fill_cnt;
    logic [SRW-1:0] sq_run;

    // Count fills and consecutive squarings since the run began.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            sq_run   <= '0;
        end else if (start && !busy) begin
            fill_cnt <= '0;
            sq_run   <= '0;
        end else if (mul_go) begin
            if (mul_kind == 2'd1) fill_cnt <= fill_cnt + 1'b1;
            if (mul_kind == 2'd2) sq_run <= sq_run + 1'b1;
            if (mul_kind == 2'd3) sq_run <= '0;
        end
    end

    // R3
    fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_go && mul_kind == 2'd1) |-> ({1'b0, tbl_addr} == fill_cnt + 1'b1));
    // R3
    fill_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_go && mul_kind == 2'd2) |-> (fill_cnt == (M+1)'((1 << M) - 1)));
    // R5
    sq_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_go && mul_kind == 2'd3) |-> (sq_run == SRW'(M)));
    // R5
    sq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_go && mul_kind == 2'd2) |-> (sq_run < SRW'(M)));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8
    go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go |-> (busy && mul_kind != 2'd0));
    // R8
    go_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go |=> !mul_go);
    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind wexp_seq wexp_chk #(.M(M)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start_i), .busy(busy_o), .done(done_o),
    .mul_go(mul_go_o), .mul_kind(mul_kind_o), .tbl_addr(tbl_addr_o)
);

// File: tb/sim_wexp_seq.sv
// Bench: vector table against a square-and-multiply reference, then directed tests.
module sim_wexp_seq;
    localparam int CLK_P = 10;
    localparam int W  = 32;
    localparam int M  = 4;
    localparam int EW = 32;
    localparam int ND = (EW + M - 1) / M;
    localparam int NFILL = (1 << M) - 1;
    localparam int NOPS = NFILL + ND * (M + 1);
    localparam int NV = 10;

    // {base, modulus, exponent}
    localparam logic [95:0] VEC [NV] = '{
        {32'h0000_0003, 32'h0000_0007, 32'h0000_0000},
        {32'h0000_0005, 32'h000F_4243, 32'h0007_0000},
        {32'h1234_5678, 32'hFFFF_FFFB, 32'hDEAD_BEEF},
        {32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0003},
        {32'h0000_0000, 32'h0000_000D, 32'h0000_0005},
        {32'h0000_0000, 32'h0000_000D, 32'h0000_0000},
        {32'h0000_0001, 32'h0000_0002, 32'hFFFF_FFFF},
        {32'h0000_0002, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'hABCD_EF01, 32'hF000_0001, 32'h8000_0000},
        {32'h0000_0011, 32'h0000_0065, 32'h0000_0001}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [W-1:0] base = '0, modv = '0;
    logic [EW-1:0] expv = '0;
    logic busy, done, mul_go;
    logic [W-1:0] result;
    logic [1:0] mul_kind;
    logic [M-1:0] tbl_addr;
    int n_chk = 0, n_bad = 0;
    int ref_lat = -1;

    always #(CLK_P/2) clk = ~clk;

    wexp_seq #(.W(W), .M(M), .EW(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .mod_i(modv),
        .exp_i(expv), .busy_o(busy), .done_o(done), .result_o(result),
        .mul_go_o(mul_go), .mul_kind_o(mul_kind), .tbl_addr_o(tbl_addr)
    );

    function automatic logic [31:0] ref_pow(logic [31:0] b, logic [31:0] e, logic [31:0] n);
        logic [63:0] r, x, nn;
        nn = {32'd0, n};
        r = 64'd1 % nn;
        x = {32'd0, b} % nn;
        for (int i = 0; i < 32; i++) begin
            if (e[i]) r = (r * x) % nn;
            x = (x * x) % nn;
        end
        return r[31:0];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    // One run; optional spurious start at cycle intr_at (0 = none).
    task automatic run_one(input logic [31:0] b, input logic [31:0] n, input logic [31:0] e,
                           input int intr_at, output logic [31:0] res, output int lat,
                           output int nops, output int patbad);
        int cyc;
        @(negedge clk);
        base = b; modv = n; expv = e; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1; nops = 0; patbad = 0; res = '0;
        forever begin
            if (mul_go) begin
                logic [1:0] ek;
                logic [3:0] ea;
                if (nops < NFILL) begin
                    ek = 2'd1; ea = 4'(nops + 1);
                end else begin
                    int t, d;
                    t = nops - NFILL;
                    d = ND - 1 - t / (M + 1);
                    if (t % (M + 1) < M) begin ek = 2'd2; ea = 4'd0; end
                    else begin ek = 2'd3; ea = 4'((e >> (d * M)) & 32'hF); end
                end
                if (mul_kind !== ek || (ek != 2'd2 && tbl_addr !== ea)) patbad++;
                nops++;
            end
            if (done) begin res = result; break; end
            if (cyc > 30000) break;
            if (cyc == intr_at) begin
                start = 1'b1; base = ~b; modv = 32'd3; expv = ~e;
            end else begin
                start = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        lat = cyc;
    endtask

    initial begin
        #(CLK_P * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] res;
        int lat, nops, patbad;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 done", 64'(done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mul_go", 64'(mul_go), 64'd0);

        for (int v = 0; v < NV; v++) begin
            logic [31:0] vb, vn, ve;
            {vb, vn, ve} = VEC[v];
            run_one(vb, vn, ve, 0, res, lat, nops, patbad);
            check("R4 result", 64'(res), 64'(ref_pow(vb, ve, vn)));
            check("R6 op count", 64'(nops), 64'(NOPS));
            if (ref_lat < 0) ref_lat = lat;
            check("R6 constant latency", 64'(lat), 64'(ref_lat));
            check("R3 R5 R6 op sequence", 64'(patbad), 64'd0);
        end

        // R2: start during a run is ignored; R7: done lasts one cycle with busy low
        run_one(32'h0000_BEEF, 32'h7FFF_FFFF, 32'h0102_0304, 200, res, lat, nops, patbad);
        check("R2 ignored start", 64'(res), 64'(ref_pow(32'h0000_BEEF, 32'h0102_0304, 32'h7FFF_FFFF)));
        check("R7 busy at done", 64'(busy), 64'd0);
        @(negedge clk);
        check("R7 done pulse", 64'(done), 64'd0);
        check("R2 stays idle", 64'(busy), 64'd0);

        // R2: busy rises the cycle after start
        @(negedge clk);
        base = 32'd2; modv = 32'd11; expv = 32'd10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", 64'(busy), 64'd1);
        while (!done) @(negedge clk);
        check("R4 second run", 64'(result), 64'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule